// File: doc/BRIEF.md
# Stuck-At Fault Coverage Harness

This block grades a set of test vectors against a small, fixed combinational circuit. It holds two copies of that circuit: a reference copy that is always fault-free, and a second copy on which exactly one internal node can be forced to a constant 0 or a constant 1. Vectors are loaded through a stream port into a small store. A start pulse then makes the harness walk through every node in turn, first holding it at 0 and then at 1. For each such fault it applies the stored vectors in order to both copies and compares the two output words.

A fault counts as detected as soon as any vector makes the outputs differ. Once that happens the remaining vectors are skipped for that fault. When every node and polarity has been tried, the harness pulses done. Its two counters then give detected faults and total faults, and their ratio is the fault coverage of the vector set.

The vector port follows valid/ready rules. A vector transfers on a rising edge where both `vec_valid` and `vec_ready` are high. The producer may hold `vec_valid` high for as long as `vec_ready` is low, and nothing is lost while it waits. `vec_ready` is low whenever a run is in progress or the store is full.

Top module: `saf_cov_harness`

## Requirements
- R1: After reset, `busy` and `done` are low, both counters read 0 and `vec_ready` is high.
- R2: A vector is stored on each edge where `vec_valid` and `vec_ready` are both high. `vec_ready` is high only when no run is active and fewer than `VEC_DEPTH` (default 8) vectors are stored. A vector accepted in the same cycle as `start` takes part in that run. The store is emptied when a run finishes. Bit 0 of `vec_data` is input a, bit 1 is b, bit 2 is c and bit 3 is d.
- R3: The circuit under test has eight nodes. Nodes 0 to 3 are the inputs a, b, c and d. Node 4 = a AND b, node 5 = c OR d, node 6 = node4 XOR node5, and node 7 = NOT(b AND c). The output bit 0 is node 6, and output bit 1 is node 7 AND d.
- R4: Fault number f forces node f/2 to the value f mod 2, which means SA0 comes before SA1 for each node. The forced value is seen by every consumer of that node. Only one fault is active at a time, and none is active outside a run.
- R5: A fault is detected when at least one applied vector gives different outputs on the two copies. With an empty store, no fault is detected.
- R6: Each fault uses one cycle per vector applied, in stored order. The first mismatch ends that fault, and the next fault starts in the following cycle. With an empty store, each fault takes one cycle. `busy` is high for exactly the sum of these cycles.
- R7: At the end of a run, `tot_count` equals 16, which is twice the node count, and `det_count` is at most `tot_count`.
- R8: `done` is high for exactly one cycle, in the cycle after the last fault (node 7, SA1) is evaluated, and `busy` falls at the same time. Both counters then hold their values until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a coverage run (taken only when idle) |
| vec_valid | input | 1 | Vector on `vec_data` is offered |
| vec_ready | output | 1 | Store can accept a vector this cycle |
| vec_data | input | 4 | Test vector {d,c,b,a} |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| det_count | output | 5 | Number of faults detected |
| tot_count | output | 5 | Number of faults evaluated |

## Verification
The bench measures how many cycles `busy` stays high and compares that with a model of the early exit on the first mismatch. A harness that keeps applying vectors after a detection would produce the right counts but the wrong run length. Vector sets are chosen to give partial coverage, full coverage and, with an empty store, none at all. An empty-store run straight after another run shows whether the store was really cleared. A design that forgot to clear it would report detections that should not be there. The bench also fills the store to its limit to confirm that ready drops, fires a second start in the middle of a run to show that it changes neither the timing nor the counts, and checks that the counters stay frozen after done.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int NODES  = 8;
  localparam int IN_W   = 4;
  localparam int OUT_W  = 2;
  localparam int FAULTS = 2 * NODES;
  localparam int FW     = $clog2(FAULTS);
  localparam int NW     = $clog2(NODES);
  localparam int CNT_W  = $clog2(FAULTS + 1);
endpackage

// File: rtl/saf_cut.sv
module saf_cut
  import saf_pkg::*;
(
  input  logic [IN_W-1:0]  x,
  input  logic             f_en,
  input  logic [NW-1:0]    f_node,
  input  logic             f_val,
  output logic [OUT_W-1:0] y
);
  logic na, nb, nc, nd, n_and, n_or, n_xor, n_nand;

  function automatic logic frc(input logic v, input int idx, input logic en,
                               input logic [NW-1:0] sel, input logic fv);
    return (en && (sel == NW'(idx))) ? fv : v;
  endfunction

  always_comb begin
    na     = frc(x[0], 0, f_en, f_node, f_val);
    nb     = frc(x[1], 1, f_en, f_node, f_val);
    nc     = frc(x[2], 2, f_en, f_node, f_val);
    nd     = frc(x[3], 3, f_en, f_node, f_val);
    n_and  = frc(na & nb, 4, f_en, f_node, f_val);
    n_or   = frc(nc | nd, 5, f_en, f_node, f_val);
    n_xor  = frc(n_and ^ n_or, 6, f_en, f_node, f_val);
    n_nand = frc(~(nb & nc), 7, f_en, f_node, f_val);
    y      = {n_nand & nd, n_xor};
  end
endmodule

// File: rtl/saf_vec_store.sv
module saf_vec_store
  import saf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic            clr,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  input  logic [AW-1:0]   rd_idx,
  output logic [IN_W-1:0] rd_data,
  output logic [CW-1:0]   count
);
  logic [IN_W-1:0] mem [DEPTH];

  assign in_ready = load_en && (count < CW'(DEPTH));
  assign rd_data  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (in_valid && in_ready) begin
      mem[count[AW-1:0]] <= in_data;
      count <= count + CW'(1);
    end
  end

  a_r2_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_hold_while_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clr) |=> $stable(count));
endmodule

// File: rtl/saf_seq.sv
module saf_seq
  import saf_pkg::*;
#(
  parameter int AW = 3,
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    vec_cnt,
  input  logic             miss,
  output logic [AW-1:0]    vidx,
  output logic             f_en,
  output logic [NW-1:0]    f_node,
  output logic             f_val,
  output logic             clr,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] det,
  output logic [CNT_W-1:0] tot
);
  logic [FW-1:0] fidx;
  logic hit, eval_end, last_f;

  always_comb begin
    hit      = miss && (vec_cnt != '0);
    eval_end = busy && (hit || (vec_cnt == '0) || ((CW'(vidx) + CW'(1)) == vec_cnt));
    last_f   = (fidx == FW'(FAULTS - 1));
    clr      = eval_end && last_f;
  end

  assign f_en   = busy;
  assign f_node = fidx[FW-1:1];
  assign f_val  = fidx[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      fidx <= '0;
      vidx <= '0;
      det  <= '0;
      tot  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          fidx <= '0;
          vidx <= '0;
          det  <= '0;
          tot  <= '0;
        end
      end else if (eval_end) begin
        vidx <= '0;
        tot  <= tot + CNT_W'(1);
        if (hit) det <= det + CNT_W'(1);
        if (last_f) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          fidx <= fidx + FW'(1);
        end
      end else begin
        vidx <= vidx + AW'(1);
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(det) && $stable(tot)));
  a_r7_total_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tot == CNT_W'(FAULTS)));
  a_r7_det_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    det <= tot);
  a_r6_fault_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eval_end) |=> $stable(fidx));
  a_r9_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> busy);
endmodule

// File: rtl/saf_cov_harness.sv
module saf_cov_harness
  import saf_pkg::*;
#(
  parameter int VEC_DEPTH = 8,
  localparam int AW = (VEC_DEPTH > 1) ? $clog2(VEC_DEPTH) : 1,
  localparam int CW = $clog2(VEC_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             vec_valid,
  output logic             vec_ready,
  input  logic [IN_W-1:0]  vec_data,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] det_count,
  output logic [CNT_W-1:0] tot_count
);
  logic [AW-1:0]    vidx;
  logic [IN_W-1:0]  cur_vec;
  logic [CW-1:0]    vec_cnt;
  logic             f_en, f_val, clr, miss;
  logic [NW-1:0]    f_node;
  logic [OUT_W-1:0] y_ref, y_flt;

  saf_vec_store #(.DEPTH(VEC_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .load_en(!busy), .clr(clr),
    .in_valid(vec_valid), .in_ready(vec_ready), .in_data(vec_data),
    .rd_idx(vidx), .rd_data(cur_vec), .count(vec_cnt)
  );

  saf_cut u_ref (
    .x(cur_vec), .f_en(1'b0), .f_node('0), .f_val(1'b0), .y(y_ref)
  );

  saf_cut u_flt (
    .x(cur_vec), .f_en(f_en), .f_node(f_node), .f_val(f_val), .y(y_flt)
  );

  assign miss = |(y_ref ^ y_flt);

  saf_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_cnt(vec_cnt), .miss(miss),
    .vidx(vidx), .f_en(f_en), .f_node(f_node), .f_val(f_val), .clr(clr),
    .busy(busy), .done(done), .det(det_count), .tot(tot_count)
  );

  a_r4_idle_match: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (y_ref == y_flt));
  a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !vec_ready);
endmodule

// File: tb/saf_cov_harness_bench.sv
module saf_cov_harness_bench;
  import saf_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [3:0] vec_data = '0;
  logic busy, done;
  logic [4:0] det_count, tot_count;

  int n_tests = 0;
  int n_fail = 0;
  int busy_cyc = 0;
  int cycles = 0;

  typedef struct { int det; int tot; int cyc; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  saf_cov_harness u_saf_cov_harness (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data), .busy(busy), .done(done),
    .det_count(det_count), .tot_count(tot_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of the circuit from R3, with the fault rule from R4
  function automatic logic [1:0] model(input logic [3:0] x, input bit fe,
                                       input int node, input logic fv);
    logic [7:0] n;
    n[0] = (fe && node == 0) ? fv : x[0];
    n[1] = (fe && node == 1) ? fv : x[1];
    n[2] = (fe && node == 2) ? fv : x[2];
    n[3] = (fe && node == 3) ? fv : x[3];
    n[4] = (fe && node == 4) ? fv : (n[0] & n[1]);
    n[5] = (fe && node == 5) ? fv : (n[2] | n[3]);
    n[6] = (fe && node == 6) ? fv : (n[4] ^ n[5]);
    n[7] = (fe && node == 7) ? fv : ~(n[1] & n[2]);
    return {n[7] & n[3], n[6]};
  endfunction

  function automatic exp_t expect_run(input logic [3:0] v[$]);
    exp_t e;
    e.det = 0; e.tot = 16; e.cyc = 0;
    for (int f = 0; f < 16; f++) begin
      if (v.size() == 0) e.cyc++;
      for (int i = 0; i < v.size(); i++) begin
        e.cyc++;
        if (model(v[i], 1'b0, 0, 1'b0) != model(v[i], 1'b1, f / 2, logic'(f % 2))) begin
          e.det++;
          break;
        end
      end
    end
    return e;
  endfunction

  task automatic send(input logic [3:0] v);
    vec_valid = 1'b1;
    vec_data  = v;
    #1;
    while (!vec_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  // driver: load vectors, push expectation, start, wait for done
  task automatic run_case(input logic [3:0] v[$], input bit poke_start);
    exp_t e;
    foreach (v[i]) send(v[i]);
    e = expect_run(v);
    sb_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(det_count == 5'(e.det), "R8 det held after done", det_count, e.det);
    chk(tot_count == 5'(e.tot), "R8 tot held after done", tot_count, e.tot);
    chk(vec_ready == 1'b1, "R2 ready after run", vec_ready, 1);
  endtask

  // monitor: count busy cycles and compare at done
  always @(negedge clk) begin
    exp_t e;
    if (busy) busy_cyc++;
    if (done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        e = sb_q.pop_front();
        chk(det_count == 5'(e.det), "R5 detected count", det_count, e.det);
        chk(tot_count == 5'(e.tot), "R7 total count", tot_count, e.tot);
        chk(busy_cyc == e.cyc, "R6 run length", busy_cyc, e.cyc);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
      end
      busy_cyc = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      chk(1'b0, "watchdog", cycles, 200000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] va[$];
    logic [3:0] vb[$];
    logic [3:0] vc[$];
    logic [3:0] vd[$];
    va = '{4'h0, 4'hF, 4'h5, 4'hA, 4'h3, 4'hC, 4'h6, 4'h9};
    vb = '{4'h6};
    vc = '{};
    vd = '{4'hF, 4'h0};

    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(det_count == 0, "R1 det reset", det_count, 0);
    chk(tot_count == 0, "R1 tot reset", tot_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vec_ready == 1'b1, "R1 ready after reset", vec_ready, 1);

    run_case(vb, 1'b0);   // single vector, R3/R4 partial coverage
    run_case(vc, 1'b0);   // R2 store emptied, R5 empty store detects nothing
    run_case(vd, 1'b1);   // two vectors with a stray start (R9)

    // R2: filling the store drops ready
    foreach (va[i]) send(va[i]);
    #1;
    chk(vec_ready == 1'b0, "R2 ready low when full", vec_ready, 0);
    begin
      exp_t e;
      e = expect_run(va);
      sb_q.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      chk(vec_ready == 1'b0, "R2 ready low while busy", vec_ready, 0);
      while (!done) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(det_count == 5'(e.det), "R8 det held", det_count, e.det);
    end

    run_case(vb, 1'b0);   // repeat after full run: R2 old vectors gone
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R8 every run gave done", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule